// File: doc/BRIEF.md
# Parallel Port Extended Control Bank with Test FIFO

This block is the extended-capability register bank of a parallel port. It occupies its own eight-byte window on a simple byte bus: a write strobe, a read strobe, a 3-bit offset and a byte in each direction. The bank has three registers: an extended control register, a configuration B register and a plain data byte. It also has a small byte FIFO.

The extended control register carries a 3-bit chip-mode field in bits 7:5. It mirrors the FIFO's empty and full state in bits 0 and 1. The FIFO can be reached through offset 0 only while the mode field selects FIFO test. In any other mode, offset 0 is a plain byte register. In configuration mode, reads of offset 0 return a configuration A value that reports the FIFO word width.

Any write that changes the mode flushes the FIFO. Software can therefore fill and drain the FIFO in test mode to check its depth and its status flags. No cable transfers take place.

Read data is combinational from the current offset and state. A read strobe at offset 0 in FIFO test mode pops the shown byte at the next clock edge.

Top module: `pport_xctl`

## Requirements
- R1: After reset, offset 2 reads 0x01 (compatible mode, empty set), offset 1 reads 0x00 and offset 0 reads 0x00.
- R2: A write to offset 2 replaces only the mode field (bits 7:5, where 0 is compatible, 1 byte, 2 PP FIFO, 3 ECP FIFO, 4 EPP, 5 reserved, 6 FIFO test and 7 configuration). A read of offset 2 returns {mode, 3'b000, full, empty}, and write bits 4:0 are ignored.
- R3: A write to offset 2 whose mode field differs from the current mode empties the FIFO (bit 0 set, bit 1 clear). A write of the same mode leaves the FIFO contents in place.
- R4: In FIFO test mode (6), a write to offset 0 pushes a byte and a read of offset 0 returns the oldest byte and pops it. Order is first-in first-out over two entries, and the positions wrap.
- R5: Status bit 0 is set when the FIFO is empty and bit 1 is set when it holds two bytes. Both bits are clear when it holds one byte.
- R6: A push into a full FIFO is dropped. A read of offset 0 from an empty FIFO in test mode returns 0x00 and moves nothing.
- R7: Outside mode 6, offset 0 reads and writes a single plain byte, and the FIFO is not touched.
- R8: In configuration mode (7), a read of offset 0 returns 0x10 (width code 1 in bits 6:4 for an 8-bit FIFO). Writes to offset 0 still update the plain byte, which reads back after the bank leaves mode 7.
- R9: Offset 1 is a read/write configuration B byte.
- R10: Offsets 3 to 7 read 0xFF, and writes to them change no register.
- R11: With both strobes at offset 0 in mode 6, the pop and the push happen in the same cycle. The read returns the old head, and a full FIFO accepts the push because the pop frees a slot.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Write strobe for the addressed register |
| rd_en | input | 1 | Read strobe; it pops the FIFO at offset 0 in test mode |
| addr | input | 3 | Register offset inside the window |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Read data for the current offset and state |

## Verification
The pop and the push of the test FIFO can fall in the same cycle, because both strobes may be raised at offset 0. The bench provokes this in three states: with the FIFO full, with it empty and with one byte held. It also raises both strobes at random offsets in every mode. The bench judges each case against a reference model that applies the pop before deciding whether the push fits. It compares the returned head byte and the later status and pop order.

// File: rtl/pport_xctl_pkg.sv
package pport_xctl_pkg;

    typedef enum logic [2:0] {
        XM_COMPAT = 3'd0,
        XM_BYTE   = 3'd1,
        XM_PPFIFO = 3'd2,
        XM_ECPFIF = 3'd3,
        XM_EPP    = 3'd4,
        XM_RSVD   = 3'd5,
        XM_FTEST  = 3'd6,
        XM_CONFIG = 3'd7
    } xmode_e;

    // Configuration A width code for a FIFO word width in bits
    function automatic logic [2:0] width_code(input int unsigned w);
        case (w)
            16:      return 3'd0;
            32:      return 3'd2;
            default: return 3'd1;
        endcase
    endfunction

endpackage

// File: rtl/pport_xfifo.sv
module pport_xfifo #(
    parameter int DATA_W = 8,
    parameter int DEPTH  = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              flush,
    input  logic              push_req,
    input  logic              pop_req,
    input  logic [DATA_W-1:0] din,
    output logic [DATA_W-1:0] head,
    output logic              empty,
    output logic              full
);
    localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CNT_W = $clog2(DEPTH + 1);
    localparam logic [PTR_W-1:0] LAST = PTR_W'(DEPTH - 1);
    localparam logic [CNT_W-1:0] FULL_CNT = CNT_W'(DEPTH);

    typedef struct packed {
        logic [PTR_W-1:0] rd;
        logic [PTR_W-1:0] wr;
        logic [CNT_W-1:0] cnt;
    } ctl_t;

    ctl_t ctl_d, ctl_q;
    logic pop_ok, push_ok;
    logic [DATA_W-1:0] mem_q [DEPTH];

    always_comb begin
        ctl_d   = ctl_q;
        pop_ok  = !flush && pop_req && (ctl_q.cnt != '0);
        push_ok = !flush && push_req && ((ctl_q.cnt != FULL_CNT) || pop_ok);
        if (flush) begin
            ctl_d = '0;
        end else begin
            if (pop_ok)
                ctl_d.rd = (ctl_q.rd == LAST) ? '0 : ctl_q.rd + 1'b1;
            if (push_ok)
                ctl_d.wr = (ctl_q.wr == LAST) ? '0 : ctl_q.wr + 1'b1;
            ctl_d.cnt = ctl_q.cnt + CNT_W'(push_ok) - CNT_W'(pop_ok);
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) ctl_q <= '0;
        else        ctl_q <= ctl_d;
    end

    for (genvar g = 0; g < DEPTH; g++) begin : g_slot
        always_ff @(posedge clk) begin
            if (push_ok && (ctl_q.wr == PTR_W'(g)))
                mem_q[g] <= din;
        end
    end

    assign empty = (ctl_q.cnt == '0);
    assign full  = (ctl_q.cnt == FULL_CNT);
    assign head  = empty ? '0 : mem_q[ctl_q.rd];

    // R3
    flush_empties_chk: assert property (@(posedge clk) disable iff (!rst_n)
        flush |=> empty && !full);
    // R6
    no_underflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (pop_req && empty && !flush) |=> $stable(ctl_q.rd));
    // R6
    no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (push_req && full && !pop_req && !flush) |=> full && $stable(ctl_q.wr));
    // R5
    status_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(empty && full));

endmodule

// File: rtl/pport_xrdmux.sv
module pport_xrdmux
    import pport_xctl_pkg::*;
#(
    parameter int          ADDR_W   = 3,
    parameter logic [7:0]  CFGA_VAL = 8'h10
) (
    input  logic [ADDR_W-1:0] addr,
    input  xmode_e            mode,
    input  logic [7:0]        plain,
    input  logic [7:0]        cfgb,
    input  logic [7:0]        fifo_head,
    input  logic              empty,
    input  logic              full,
    output logic [7:0]        rdata
);
    always_comb begin
        case (addr)
            ADDR_W'(0): begin
                if (mode == XM_FTEST)       rdata = fifo_head;
                else if (mode == XM_CONFIG) rdata = CFGA_VAL;
                else                        rdata = plain;
            end
            ADDR_W'(1): rdata = cfgb;
            ADDR_W'(2): rdata = {mode, 3'b000, full, empty};
            default:    rdata = 8'hFF;
        endcase
    end
endmodule

// File: rtl/pport_xctl.sv
module pport_xctl
    import pport_xctl_pkg::*;
#(
    parameter int ADDR_W     = 3,
    parameter int FIFO_DEPTH = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic              rd_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [7:0]        wdata,
    output logic [7:0]        rdata
);
    localparam int         WORD_W   = 8;
    localparam logic [7:0] CFGA_VAL = {1'b0, width_code(WORD_W), 4'b0000};

    typedef struct packed {
        xmode_e     mode;
        logic [7:0] cfgb;
        logic [7:0] plain;
    } bank_t;

    bank_t st_d, st_q;
    logic  flush, push_req, pop_req;
    logic  f_empty, f_full;
    logic [7:0] f_head;

    always_comb begin
        st_d     = st_q;
        flush    = 1'b0;
        push_req = wr_en && (addr == ADDR_W'(0)) && (st_q.mode == XM_FTEST);
        pop_req  = rd_en && (addr == ADDR_W'(0)) && (st_q.mode == XM_FTEST);
        if (wr_en) begin
            case (addr)
                ADDR_W'(0): if (st_q.mode != XM_FTEST) st_d.plain = wdata;
                ADDR_W'(1): st_d.cfgb = wdata;
                ADDR_W'(2): begin
                    st_d.mode = xmode_e'(wdata[7:5]);
                    flush     = (wdata[7:5] != st_q.mode);
                end
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q.mode  <= XM_COMPAT;
            st_q.cfgb  <= '0;
            st_q.plain <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    pport_xfifo #(.DATA_W(WORD_W), .DEPTH(FIFO_DEPTH)) u_fifo (
        .clk      (clk),
        .rst_n    (rst_n),
        .flush    (flush),
        .push_req (push_req),
        .pop_req  (pop_req),
        .din      (wdata),
        .head     (f_head),
        .empty    (f_empty),
        .full     (f_full)
    );

    pport_xrdmux #(.ADDR_W(ADDR_W), .CFGA_VAL(CFGA_VAL)) u_rdmux (
        .addr      (addr),
        .mode      (st_q.mode),
        .plain     (st_q.plain),
        .cfgb      (st_q.cfgb),
        .fifo_head (f_head),
        .empty     (f_empty),
        .full      (f_full),
        .rdata     (rdata)
    );

    // R2
    mode_take_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && addr == ADDR_W'(2)) |=> (st_q.mode == $past(wdata[7:5])));
    // R10
    rsvd_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && addr > ADDR_W'(2)) |=> $stable(st_q));
    // R8
    cfg_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.mode == XM_CONFIG && addr == ADDR_W'(0)) |-> rdata == 8'h10);
    // R7
    plain_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.mode == XM_FTEST && !(wr_en && addr == ADDR_W'(2))) |=> $stable(st_q.plain));

endmodule

// File: tb/pport_xctl_tb.sv
module pport_xctl_tb;
    logic clk = 1'b0;
    always #5 clk = ~clk;

    logic       rst_n, wr_en, rd_en;
    logic [2:0] addr;
    logic [7:0] wdata;
    logic [7:0] rdata;

    pport_xctl u_dut (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en),
        .addr(addr), .wdata(wdata), .rdata(rdata)
    );

    int n_vec = 0;
    int n_bad = 0;
    bit done  = 1'b0;

    // reference model
    logic [2:0] m_mode;
    logic [7:0] m_cfgb, m_plain;
    logic [7:0] m_q [2];
    int m_rd, m_wr, m_cnt;

    function automatic logic [7:0] exp_read(input logic [2:0] a);
        case (a)
            3'd0: begin
                if (m_mode == 3'd6) return (m_cnt == 0) ? 8'h00 : m_q[m_rd];
                if (m_mode == 3'd7) return 8'h10;
                return m_plain;
            end
            3'd1: return m_cfgb;
            3'd2: return {m_mode, 3'b000, (m_cnt == 2), (m_cnt == 0)};
            default: return 8'hFF;
        endcase
    endfunction

    function automatic string req_for(input logic [2:0] a);
        if (a == 3'd0) return (m_mode == 3'd6) ? "R4" : ((m_mode == 3'd7) ? "R8" : "R7");
        if (a == 3'd1) return "R9";
        if (a == 3'd2) return "R2";
        return "R10";
    endfunction

    task automatic model_step(input bit rd, input bit wr, input logic [2:0] a, input logic [7:0] d);
        bit pop_ok, push_ok;
        pop_ok  = rd && a == 3'd0 && m_mode == 3'd6 && m_cnt > 0;
        push_ok = wr && a == 3'd0 && m_mode == 3'd6 && (m_cnt < 2 || pop_ok);
        if (wr && a == 3'd0 && m_mode != 3'd6) m_plain = d;
        if (wr && a == 3'd1) m_cfgb = d;
        if (pop_ok) begin m_rd = (m_rd + 1) % 2; m_cnt--; end
        if (push_ok) begin m_q[m_wr] = d; m_wr = (m_wr + 1) % 2; m_cnt++; end
        if (wr && a == 3'd2) begin
            if (d[7:5] != m_mode) begin m_rd = 0; m_wr = 0; m_cnt = 0; end
            m_mode = d[7:5];
        end
    endtask

    task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
        n_vec++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: rdata got %02h expected %02h", req, act, exp);
        end
    endtask

    // one bus cycle; a read is checked against the model before the model updates
    task automatic bus(input bit rd, input bit wr, input logic [2:0] a, input logic [7:0] d, input string req);
        @(negedge clk);
        rd_en = rd; wr_en = wr; addr = a; wdata = d;
        #2;
        if (rd) check((req == "") ? req_for(a) : req, rdata, exp_read(a));
        model_step(rd, wr, a, d);
    endtask

    task automatic wr_reg(input logic [2:0] a, input logic [7:0] d);
        bus(1'b0, 1'b1, a, d, "");
    endtask

    task automatic rd_reg(input logic [2:0] a, input string req);
        bus(1'b1, 1'b0, a, 8'h00, req);
    endtask

    task automatic summary;
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    endtask

    initial begin
        #(200000 * 10);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog: run did not finish, got hang expected completion");
            summary();
            $finish;
        end
    end

    initial begin
        void'($urandom(32'h5EED_0042));
        rst_n = 1'b0; wr_en = 1'b0; rd_en = 1'b0; addr = '0; wdata = '0;
        m_mode = 3'd0; m_cfgb = 8'h00; m_plain = 8'h00;
        m_q[0] = 8'h00; m_q[1] = 8'h00; m_rd = 0; m_wr = 0; m_cnt = 0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1 reset state
        rd_reg(3'd2, "R1"); rd_reg(3'd1, "R1"); rd_reg(3'd0, "R1");
        // R2 mode field only
        wr_reg(3'd2, 8'h1F); rd_reg(3'd2, "R2");
        wr_reg(3'd2, 8'h3F); rd_reg(3'd2, "R2");
        // R7 plain byte
        wr_reg(3'd0, 8'hA5); rd_reg(3'd0, "R7");
        // R9
        wr_reg(3'd1, 8'h3C); rd_reg(3'd1, "R9");
        // R4 / R5 / R6 fifo test mode
        wr_reg(3'd2, 8'hC0); rd_reg(3'd2, "R5");
        wr_reg(3'd0, 8'h11); rd_reg(3'd2, "R5");
        wr_reg(3'd0, 8'h22); rd_reg(3'd2, "R5");
        wr_reg(3'd0, 8'h33); rd_reg(3'd2, "R6");
        rd_reg(3'd0, "R4"); rd_reg(3'd0, "R4"); rd_reg(3'd2, "R5");
        rd_reg(3'd0, "R6"); rd_reg(3'd2, "R6");
        wr_reg(3'd0, 8'h44); rd_reg(3'd0, "R4");
        // R11 pop and push together: full, then empty, then one held
        wr_reg(3'd0, 8'h55); wr_reg(3'd0, 8'h66);
        bus(1'b1, 1'b1, 3'd0, 8'h77, "R11"); rd_reg(3'd2, "R11");
        rd_reg(3'd0, "R11"); rd_reg(3'd0, "R11");
        bus(1'b1, 1'b1, 3'd0, 8'h78, "R11"); rd_reg(3'd2, "R11");
        bus(1'b1, 1'b1, 3'd0, 8'h79, "R11"); rd_reg(3'd0, "R11");
        // R3 same mode keeps, different mode flushes
        wr_reg(3'd0, 8'h88); wr_reg(3'd2, 8'hC0); rd_reg(3'd2, "R3");
        wr_reg(3'd2, 8'hE0); rd_reg(3'd2, "R3");
        // R8 configuration mode
        rd_reg(3'd0, "R8"); wr_reg(3'd0, 8'h5A); rd_reg(3'd0, "R8");
        wr_reg(3'd2, 8'h00); rd_reg(3'd0, "R8");
        wr_reg(3'd2, 8'hC0); rd_reg(3'd2, "R3"); rd_reg(3'd0, "R3");
        // R10 reserved offsets
        for (int k = 3; k < 8; k++) begin
            wr_reg(3'(k), 8'h00); rd_reg(3'(k), "R10");
        end
        rd_reg(3'd1, "R10"); rd_reg(3'd2, "R10");
        wr_reg(3'd2, 8'h00); rd_reg(3'd0, "R10");

        // constrained random traffic
        for (int i = 0; i < 4000; i++) begin
            logic [2:0] a;
            logic [7:0] d;
            bit rd, wr;
            a  = ($urandom % 4 == 0) ? 3'($urandom % 8) : (($urandom % 3 != 0) ? 3'd0 : 3'd2);
            d  = 8'($urandom);
            if (a == 3'd2 && ($urandom % 3 != 0)) d[7:5] = ($urandom % 4 == 0) ? 3'd7 : 3'd6;
            rd = ($urandom % 2 == 1);
            wr = ($urandom % 2 == 1);
            bus(rd, wr, a, d, "");
        end

        @(negedge clk);
        rd_en = 1'b0; wr_en = 1'b0;
        done = 1'b1;
        summary();
        $finish;
    end
endmodule